// File: doc/BRIEF.md
# Seconds Drift Compensator

This block sits between a raw once-per-second tick and the seconds counter that follows it. It corrects the long-term rate of that counter by adding or removing a whole second at a fixed interval. A configuration word selects the interval (a 19-bit match count N), the direction (a 2-bit mode) and whether correction is active at all (a valid flag). While correction is active, one raw second in every N+1 is treated as a correction point. Removing a second per N+1 seconds gives a rate offset of -1e9/(N+1) ppb. Adding one gives +1e9/(N+1) ppb. Software works out N from a desired ppb offset; this block only applies it.

An internal second counter advances on every raw tick while correction is active. It wraps to zero when it equals the match count, and that tick is the correction point. In drop mode the raw tick at the correction point is withheld. In add mode that tick is passed on, and a second output pulse follows a fixed number of fast-clock cycles later. The delay keeps the two pulses apart so they never fall in the same cycle. Every passed tick appears on the output one fast-clock cycle after the raw tick.

A small state machine produces the extra pulse. Its states are:
- ST_PASS: the normal state, in which raw ticks are forwarded or dropped.
- ST_DELAY: a countdown of GAP_CYC cycles.
- ST_EMIT: the state that produces the extra pulse.

Its transitions are:
- pass_to_delay: taken on a raw tick at a correction point in add mode.
- delay_hold: the countdown is still running.
- delay_to_emit: the countdown has reached zero.
- emit_to_pass: taken unconditionally one cycle after entering ST_EMIT.

Top module: `sec_drift_comp`

## Requirements
- R1: During and right after reset tick_out is 0, and the configuration is cleared, so that valid is 0.
- R2: With the valid flag (bit 23) at 0, every raw tick is forwarded and no tick is added or removed, whatever the other bits hold.
- R3: With valid at 1 and mode (bits [20:19]) equal to 0 or 1, every raw tick is forwarded unchanged.
- R4: With valid at 1 and mode 2 (drop), the raw ticks numbered N+1, 2(N+1), … after a configuration write are withheld, and all other ticks are forwarded. N is bits [18:0]. With N=0 every tick is withheld.
- R5: With valid at 1 and mode 3 (add), the tick at each correction point is forwarded and is followed by one extra pulse GAP_CYC+1 cycles after the forwarded pulse. GAP_CYC defaults to 4.
- R6: A forwarded tick is high on tick_out for exactly the one cycle after the cycle in which tick_in was sampled high.
- R7: A write to the adjust register resets the internal second counter to zero, so counting to the next correction point starts afresh.
- R8: Only a write whose cfg_addr equals the adjust register byte offset 0x18 changes the configuration. Writes to any other address have no effect.
- R9: tick_out is a single-cycle pulse and is never high in two consecutive cycles, given raw ticks at least GAP_CYC+3 cycles apart.
- R10: Bits of the configuration word outside [23], [20:19] and [18:0] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Raw one-second tick, one cycle wide |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (8) | Byte address of the write |
| cfg_wdata | input | DATA_W (32) | Write data |
| tick_out | output | 1 | Adjusted tick to the seconds counter |

## Verification
The assertions assume that tick_in is a single-cycle pulse. They also assume that consecutive raw ticks are separated by more than GAP_CYC+2 cycles, so a forwarded tick never lands on the cycle of a pending extra pulse. They further assume that configuration writes do not coincide with a raw tick. The stimulus keeps to these assumptions: every tick is followed by twelve idle cycles, which is well above the default gap. Every configuration write also completes before the next tick is driven.

// File: rtl/dcomp_pkg.sv
package dcomp_pkg;
    typedef enum logic [1:0] {
        MODE_NONE0 = 2'd0,
        MODE_NONE1 = 2'd1,
        MODE_DROP  = 2'd2,
        MODE_ADD   = 2'd3
    } adj_mode_e;

    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_DELAY = 2'd1,
        ST_EMIT  = 2'd2
    } fsm_st_e;
endpackage

// File: rtl/dcomp_cfg_reg.sv
module dcomp_cfg_reg
    import dcomp_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] ADJ_ADDR  = 8'h18,
    parameter int                MATCH_W   = 19,
    parameter int                MODE_LSB  = 19,
    parameter int                VALID_BIT = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic               wr_hit,
    output logic [MATCH_W-1:0] match_q,
    output adj_mode_e          mode_q,
    output logic               valid_q
);
    assign wr_hit = cfg_we && (cfg_addr == ADJ_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= '0;
            mode_q  <= MODE_NONE0;
            valid_q <= 1'b0;
        end else if (wr_hit) begin
            match_q <= cfg_wdata[MATCH_W-1:0];
            mode_q  <= adj_mode_e'(cfg_wdata[MODE_LSB+1:MODE_LSB]);
            valid_q <= cfg_wdata[VALID_BIT];
        end
    end
endmodule

// File: rtl/dcomp_sec_cnt.sv
module dcomp_sec_cnt #(
    parameter int MATCH_W = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               tick,
    input  logic [MATCH_W-1:0] match_val,
    output logic               hit,
    output logic [MATCH_W-1:0] cnt
);
    logic at_match;

    assign at_match = (cnt == match_val);
    assign hit      = en && tick && at_match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_match ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dcomp_tick_fsm.sv
module dcomp_tick_fsm
    import dcomp_pkg::*;
#(
    parameter int GAP_CYC = 4,
    localparam int GAP_W  = $clog2(GAP_CYC + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_in,
    input  logic    hit,
    input  logic    drop_en,
    input  logic    add_en,
    output logic    tick_out,
    output fsm_st_e state
);
    fsm_st_e          state_nx;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] gap_nx;

    always_comb begin
        state_nx = state;
        gap_nx   = gap_q;
        unique case (state)
            ST_PASS: begin
                if (tick_in && hit && add_en) begin
                    state_nx = ST_DELAY;
                    gap_nx   = GAP_W'(GAP_CYC - 1);
                end
            end
            ST_DELAY: begin
                if (gap_q == '0) state_nx = ST_EMIT;
                else             gap_nx   = gap_q - 1'b1;
            end
            ST_EMIT: begin
                state_nx = ST_PASS;
            end
            default: state_nx = ST_PASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PASS;
            gap_q <= '0;
        end else begin
            state <= state_nx;
            gap_q <= gap_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_out <= 1'b0;
        end else begin
            tick_out <= (tick_in && !(hit && drop_en)) || (state == ST_EMIT);
        end
    end
endmodule

// File: rtl/sec_drift_comp.sv
module sec_drift_comp
    import dcomp_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] ADJ_ADDR  = 8'h18,
    parameter int                MATCH_W   = 19,
    parameter int                MODE_LSB  = 19,
    parameter int                VALID_BIT = 23,
    parameter int                GAP_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              tick_out
);
    logic               wr_hit;
    logic [MATCH_W-1:0] match_q;
    adj_mode_e          mode_q;
    logic               valid_q;
    logic               drop_en;
    logic               add_en;
    logic               hit;
    logic [MATCH_W-1:0] cnt;
    fsm_st_e            state;

    dcomp_cfg_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADJ_ADDR(ADJ_ADDR),
        .MATCH_W(MATCH_W), .MODE_LSB(MODE_LSB), .VALID_BIT(VALID_BIT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wr_hit(wr_hit), .match_q(match_q),
        .mode_q(mode_q), .valid_q(valid_q)
    );

    assign drop_en = valid_q && (mode_q == MODE_DROP);
    assign add_en  = valid_q && (mode_q == MODE_ADD);

    dcomp_sec_cnt #(.MATCH_W(MATCH_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(wr_hit), .en(drop_en || add_en),
        .tick(tick_in), .match_val(match_q), .hit(hit), .cnt(cnt)
    );

    dcomp_tick_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .hit(hit),
        .drop_en(drop_en), .add_en(add_en), .tick_out(tick_out),
        .state(state)
    );
endmodule

// File: rtl/sec_drift_comp_chk.sv
module sec_drift_comp_chk
    import dcomp_pkg::*;
#(
    parameter int MATCH_W = 19
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_in,
    input logic               tick_out,
    input logic               wr_hit,
    input logic               valid_q,
    input logic               drop_en,
    input logic               add_en,
    input logic               hit,
    input logic [MATCH_W-1:0] cnt,
    input fsm_st_e            state
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !tick_out);

    assert_pass_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && !valid_q) |=> tick_out);

    assert_pass_nomode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && valid_q && !drop_en && !add_en) |=> tick_out);

    assert_drop_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && hit && drop_en) |=> !tick_out);

    assert_fwd_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && !hit) |=> tick_out);

    assert_extra_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |=> tick_out);

    assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (cnt == '0));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |=> !tick_out);
endmodule

bind sec_drift_comp sec_drift_comp_chk #(.MATCH_W(MATCH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tick_out(tick_out),
    .wr_hit(wr_hit), .valid_q(valid_q), .drop_en(drop_en), .add_en(add_en),
    .hit(hit), .cnt(cnt), .state(state)
);

// File: tb/sec_drift_comp_tb.sv
module sec_drift_comp_tb;
    localparam int GAP = 4;
    localparam int IDLE_CYC = 12;

    typedef struct packed {
        logic [31:0] word;
        logic [7:0]  ticks;
        logic [7:0]  expect_out;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{32'h0090_0002, 8'd9,  8'd6},  // R4 drop, N=2
        '{32'h0098_0002, 8'd9,  8'd12}, // R5 add, N=2
        '{32'h0018_0000, 8'd5,  8'd5},  // R2 valid clear
        '{32'h0088_0000, 8'd5,  8'd5},  // R3 mode 1
        '{32'h0080_0000, 8'd5,  8'd5},  // R3 mode 0
        '{32'h0090_0000, 8'd4,  8'd0},  // R4 drop, N=0
        '{32'h0098_0000, 8'd4,  8'd8},  // R5 add, N=0
        '{32'h0098_0004, 8'd10, 8'd12}, // R5 add, N=4
        '{32'hFFF0_0001, 8'd6,  8'd3}   // R10 junk bits, drop N=1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        tick_out;

    int total = 0;
    int bad = 0;
    int out_cnt = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    sec_drift_comp u_dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .tick_out(tick_out)
    );

    always @(negedge clk) if (tick_out) out_cnt++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic tick_gap();
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        repeat (IDLE_CYC) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tick_out == 1'b0, "R1 reset out", tick_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tick_out == 1'b0, "R1 after reset", tick_out, 0);

        // R6 latency and R9 single pulse with cleared configuration
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        chk(tick_out == 1'b1, "R6 latency one", tick_out, 1);
        @(negedge clk);
        chk(tick_out == 1'b0, "R9 pulse width", tick_out, 0);
        repeat (IDLE_CYC) @(negedge clk);

        for (int i = 0; i < 9; i++) begin
            wr(8'h18, VECS[i].word);
            out_cnt = 0;
            for (int t = 0; t < int'(VECS[i].ticks); t++) tick_gap();
            chk(out_cnt == int'(VECS[i].expect_out), $sformatf("vector %0d (R2 R3 R4 R5 R10)", i),
                out_cnt, int'(VECS[i].expect_out));
        end

        // R5 exact timing of the extra pulse, add N=0
        wr(8'h18, 32'h0098_0000);
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        chk(tick_out == 1'b1, "R5 forwarded pulse", tick_out, 1);
        for (int k = 1; k <= GAP; k++) begin
            @(negedge clk);
            chk(tick_out == 1'b0, "R5 quiet gap", tick_out, 0);
        end
        @(negedge clk);
        chk(tick_out == 1'b1, "R5 extra pulse", tick_out, 1);
        @(negedge clk);
        chk(tick_out == 1'b0, "R9 extra width", tick_out, 0);
        repeat (IDLE_CYC) @(negedge clk);

        // R7 rewrite restarts counting, drop N=2
        wr(8'h18, 32'h0090_0002);
        out_cnt = 0;
        tick_gap(); tick_gap();
        wr(8'h18, 32'h0090_0002);
        tick_gap(); tick_gap(); tick_gap();
        chk(out_cnt == 4, "R7 counter restart", out_cnt, 4);

        // R8 write to another address ignored
        wr(8'h18, 32'h0090_0000);
        wr(8'h14, 32'h0000_0000);
        wr(8'h1C, 32'h0000_0000);
        out_cnt = 0;
        tick_gap(); tick_gap(); tick_gap();
        chk(out_cnt == 0, "R8 other address", out_cnt, 0);

        // R1 reset clears configuration
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(tick_out == 1'b0, "R1 in reset", tick_out, 0);
        rst_n = 1'b1;
        out_cnt = 0;
        tick_gap(); tick_gap();
        chk(out_cnt == 2, "R1 config cleared", out_cnt, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule